// File: doc/BRIEF.md
# Programmable BAR Window Decoder

This block holds a small bank of 64-bit configuration registers: one enable register, one mode register, and base and mask registers for four address windows. Software programs the bank over a simple 64-bit register write and read port. The decoder compares an incoming physical address against the four windows. Two of the windows are I/O windows whose size is set by a mask register. One is a fixed-size register window, and one is a fixed-size interrupt window.

For every window the block reports whether the address falls inside it. It also picks a single winner by fixed priority and gives the address offset inside that winner, or flags that no window matched. Each write is trimmed to the bits that the target register implements.

Software may rewrite a base or mask while its window is live. The new value is stored anyway, and a one-cycle error pulse reports the unsafe update.

Top module: `bar_window_decoder`

## Requirements
- R1: After reset every register reads zero, `bar_err` is low and `no_hit` is high for any address.
- R2: Register index 0 (enable) keeps only bits 63:60. Bit 63 enables I/O window 0, bit 62 I/O window 1, bit 61 the register window and bit 60 the interrupt window. Index 1 (mode) keeps only bits 63:56. All other bits of these two registers read zero.
- R3: Indexes 2 and 4 (I/O window 0 and 1 base) and indexes 3 and 5 (I/O window 0 and 1 mask) keep bits 63:24 of a write. Their bits 23:0 read zero.
- R4: Index 6 (register-window base) keeps bits 63:22, and index 7 (interrupt-window base) keeps bits 63:36. All lower bits read zero.
- R5: Indexes 8 to 15 read zero. A write to them changes no register and raises no error.
- R6: An I/O window's physical base is its base register shifted right by 8. Its size is the complement of its mask register, shifted right by 8, plus one. The window hits when it is enabled and base <= addr < base + size.
- R7: The register window spans NUM_REGS*8 bytes and the interrupt window spans MAX_INTS*65536 bytes. Each starts at its base register shifted right by 8 and hits only when enabled.
- R8: `win_sel` is one-hot on the highest-priority hitting window, in the order I/O 0 (bit 0), I/O 1 (bit 1), register window (bit 2), interrupt window (bit 3). When no window hits, `win_sel` is zero and `no_hit` is high.
- R9: `sel_offset` equals the address minus the winning window's physical base. It is zero when no window hits.
- R10: A write to a base or mask register of a window that is enabled at that moment still takes effect. `bar_err` is high for the one cycle after that write's clock edge.
- R11: Writes to a disabled window's registers, to the enable register or to the mode register leave `bar_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | IDX_W | Register index for the write |
| wr_data | input | DATA_W | Write data |
| rd_idx | input | IDX_W | Register index for the read |
| rd_data | output | DATA_W | Read data (combinational) |
| addr | input | DATA_W-8 | Physical address to decode |
| win_hit | output | 4 | Raw per-window hit flags |
| win_sel | output | 4 | One-hot winning window |
| no_hit | output | 1 | No window matched |
| sel_offset | output | DATA_W-8 | Offset inside winning window |
| bar_err | output | 1 | Pulse: write to a live window's base or mask |

## Verification
A corrupted base or mask register shows up on the read port directly. It also shifts the edges of a window, so an address one byte outside or inside the expected limit gives the wrong `win_hit` in the same cycle as the address is applied. A bad enable bit or a priority fault changes `win_sel` and `sel_offset` at once for any address in an overlap region. A wrong guard check shows as a missing or spurious `bar_err` one edge after the write.

// File: rtl/bar_dec_pkg.sv
package bar_dec_pkg;

   localparam int NWIN = 4;
   localparam int NREG = 8;

   typedef enum logic [1:0] {
      WIN_IO0  = 2'd0,
      WIN_IO1  = 2'd1,
      WIN_REGS = 2'd2,
      WIN_INTR = 2'd3
   } win_e;

   localparam int IDX_EN       = 0;
   localparam int IDX_MODE     = 1;
   localparam int IDX_IO0_BASE = 2;
   localparam int IDX_IO0_MASK = 3;
   localparam int IDX_IO1_BASE = 4;
   localparam int IDX_IO1_MASK = 5;
   localparam int IDX_REG_BASE = 6;
   localparam int IDX_INT_BASE = 7;

   // window that a base/mask register belongs to
   function automatic win_e win_of_idx(input int idx);
      case (idx)
         IDX_IO0_BASE, IDX_IO0_MASK: return WIN_IO0;
         IDX_IO1_BASE, IDX_IO1_MASK: return WIN_IO1;
         IDX_REG_BASE:               return WIN_REGS;
         IDX_INT_BASE:               return WIN_INTR;
         default:                    return WIN_IO0;
      endcase
   endfunction

   // registers whose rewrite is guarded by the window enable
   function automatic bit idx_guarded(input int idx);
      return (idx >= IDX_IO0_BASE) && (idx <= IDX_INT_BASE);
   endfunction

endpackage

// File: rtl/bar_cfg_regs.sv
module bar_cfg_regs
   import bar_dec_pkg::*;
#(
   parameter int DATA_W    = 64,
   parameter int IDX_W     = 4,
   parameter int SHIFT     = 8,
   parameter int IO_LSB    = 24,
   parameter int RB_LSB    = 22,
   parameter int IB_LSB    = 36,
   parameter int EN_BITS   = 4,
   parameter int MODE_BITS = 8
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               wr_en,
   input  logic [IDX_W-1:0]                   wr_idx,
   input  logic [DATA_W-1:0]                  wr_data,
   input  logic [IDX_W-1:0]                   rd_idx,
   output logic [DATA_W-1:0]                  rd_data,
   output logic [NWIN-1:0]                    win_en,
   output logic [NWIN-1:0][DATA_W-SHIFT-1:0]  win_phys,
   output logic [1:0][DATA_W-SHIFT-1:0]       io_mask_phys,
   output logic                               bar_err
);

   localparam int SEL_W = $clog2(NREG);
   localparam logic [DATA_W-1:0] ONES = '1;

   function automatic logic [DATA_W-1:0] keep_of(input int idx);
      case (idx)
         IDX_EN:                     return ~(ONES >> EN_BITS);
         IDX_MODE:                   return ~(ONES >> MODE_BITS);
         IDX_IO0_BASE, IDX_IO0_MASK,
         IDX_IO1_BASE, IDX_IO1_MASK: return ONES << IO_LSB;
         IDX_REG_BASE:               return ONES << RB_LSB;
         IDX_INT_BASE:               return ONES << IB_LSB;
         default:                    return '0;
      endcase
   endfunction

   logic [NREG-1:0][DATA_W-1:0] cfg;

   generate
      for (genvar g = 0; g < NREG; g++) begin : g_reg
         localparam logic [DATA_W-1:0] KEEP = keep_of(g);
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (wr_en && (wr_idx == IDX_W'(g)))
               q <= wr_data & KEEP;
         end
         assign cfg[g] = q;
      end
   endgenerate

   // read port: unmapped indexes return zero
   always_comb begin
      if (rd_idx < IDX_W'(NREG))
         rd_data = cfg[rd_idx[SEL_W-1:0]];
      else
         rd_data = '0;
   end

   // decoder-facing views
   generate
      for (genvar w = 0; w < NWIN; w++) begin : g_en
         assign win_en[w] = cfg[IDX_EN][DATA_W-1-w];
      end
   endgenerate

   assign win_phys[WIN_IO0]  = cfg[IDX_IO0_BASE][DATA_W-1:SHIFT];
   assign win_phys[WIN_IO1]  = cfg[IDX_IO1_BASE][DATA_W-1:SHIFT];
   assign win_phys[WIN_REGS] = cfg[IDX_REG_BASE][DATA_W-1:SHIFT];
   assign win_phys[WIN_INTR] = cfg[IDX_INT_BASE][DATA_W-1:SHIFT];
   assign io_mask_phys[0]    = cfg[IDX_IO0_MASK][DATA_W-1:SHIFT];
   assign io_mask_phys[1]    = cfg[IDX_IO1_MASK][DATA_W-1:SHIFT];

   // live-window rewrite detection
   logic guarded;
   win_e wr_win;
   logic err_d;
   logic err_q;

   always_comb begin
      guarded = 1'b0;
      wr_win  = WIN_IO0;
      if (wr_idx < IDX_W'(NREG)) begin
         guarded = idx_guarded(int'(wr_idx));
         wr_win  = win_of_idx(int'(wr_idx));
      end
      err_d = wr_en && guarded && win_en[wr_win];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         err_q <= 1'b0;
      else
         err_q <= err_d;
   end

   assign bar_err = err_q;

endmodule

// File: rtl/bar_window.sv
module bar_window #(
   parameter int ADDR_W = 56
) (
   input  logic              en,
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W:0]   size,
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic [ADDR_W-1:0] offset
);

   // one extra bit so base+size never wraps
   logic [ADDR_W:0] limit;

   always_comb begin
      limit  = {1'b0, base} + size;
      hit    = en && (addr >= base) && ({1'b0, addr} < limit);
      offset = addr - base;
   end

endmodule

// File: rtl/bar_prio.sv
module bar_prio #(
   parameter int N = 4,
   parameter int W = 56
) (
   input  logic [N-1:0]        hit,
   input  logic [N-1:0][W-1:0] off,
   output logic [N-1:0]        sel,
   output logic                nohit,
   output logic [W-1:0]        off_o
);

   logic [N:0] taken;
   assign taken[0] = 1'b0;

   generate
      for (genvar i = 0; i < N; i++) begin : g_chain
         assign sel[i]     = hit[i] && !taken[i];
         assign taken[i+1] = taken[i] | hit[i];
      end
   endgenerate

   assign nohit = !taken[N];

   always_comb begin
      off_o = '0;
      for (int i = 0; i < N; i++) begin
         if (sel[i])
            off_o = off_o | off[i];
      end
   end

endmodule

// File: rtl/bar_window_decoder.sv
module bar_window_decoder
   import bar_dec_pkg::*;
#(
   parameter int DATA_W    = 64,
   parameter int IDX_W     = 4,
   parameter int SHIFT     = 8,
   parameter int IO_LSB    = 24,
   parameter int RB_LSB    = 22,
   parameter int IB_LSB    = 36,
   parameter int NUM_REGS  = 1024,
   parameter int MAX_INTS  = 256,
   parameter int ADDR_W    = DATA_W - SHIFT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data,
   input  logic [ADDR_W-1:0] addr,
   output logic [3:0]        win_hit,
   output logic [3:0]        win_sel,
   output logic              no_hit,
   output logic [ADDR_W-1:0] sel_offset,
   output logic              bar_err
);

   localparam logic [63:0] REG_BYTES = 64'(NUM_REGS) * 64'd8;
   localparam logic [63:0] INT_BYTES = 64'(MAX_INTS) << 16;
   localparam logic [ADDR_W:0] REG_SIZE = (ADDR_W+1)'(REG_BYTES);
   localparam logic [ADDR_W:0] INT_SIZE = (ADDR_W+1)'(INT_BYTES);

   // elaboration-time parameter checks
   generate
      if (ADDR_W != DATA_W - SHIFT)
         $error("ADDR_W must equal DATA_W - SHIFT");
      if (IO_LSB <= SHIFT || RB_LSB <= SHIFT || IB_LSB <= SHIFT)
         $error("base fields must lie above the shift amount");
      if (IB_LSB >= DATA_W || IO_LSB >= DATA_W || RB_LSB >= DATA_W)
         $error("base field low bit outside the register");
      if (IDX_W <= $clog2(NREG))
         $error("IDX_W too narrow for the register bank");
      if (REG_BYTES > (64'd1 << RB_LSB - SHIFT))
         $error("register window larger than its base alignment");
      if (NUM_REGS < 1 || MAX_INTS < 1)
         $error("window sizes must be non-zero");
   endgenerate

   logic [NWIN-1:0]                   win_en;
   logic [NWIN-1:0][ADDR_W-1:0]       win_phys;
   logic [1:0][ADDR_W-1:0]            io_mask_phys;
   logic [NWIN-1:0][ADDR_W:0]         win_size;
   logic [NWIN-1:0][ADDR_W-1:0]       win_off;

   bar_cfg_regs #(
      .DATA_W    (DATA_W),
      .IDX_W     (IDX_W),
      .SHIFT     (SHIFT),
      .IO_LSB    (IO_LSB),
      .RB_LSB    (RB_LSB),
      .IB_LSB    (IB_LSB),
      .EN_BITS   (NWIN),
      .MODE_BITS (8)
   ) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (wr_en),
      .wr_idx       (wr_idx),
      .wr_data      (wr_data),
      .rd_idx       (rd_idx),
      .rd_data      (rd_data),
      .win_en       (win_en),
      .win_phys     (win_phys),
      .io_mask_phys (io_mask_phys),
      .bar_err      (bar_err)
   );

   generate
      for (genvar w = 0; w < NWIN; w++) begin : g_win
         if (w < 2) begin : g_io
            // size from complemented mask
            assign win_size[w] = {1'b0, ~io_mask_phys[w]} + {{ADDR_W{1'b0}}, 1'b1};
         end else if (w == int'(WIN_REGS)) begin : g_regwin
            assign win_size[w] = REG_SIZE;
         end else begin : g_intwin
            assign win_size[w] = INT_SIZE;
         end

         bar_window #(.ADDR_W(ADDR_W)) u_win (
            .en     (win_en[w]),
            .base   (win_phys[w]),
            .size   (win_size[w]),
            .addr   (addr),
            .hit    (win_hit[w]),
            .offset (win_off[w])
         );
      end
   endgenerate

   bar_prio #(.N(NWIN), .W(ADDR_W)) u_prio (
      .hit   (win_hit),
      .off   (win_off),
      .sel   (win_sel),
      .nohit (no_hit),
      .off_o (sel_offset)
   );

endmodule

// File: rtl/bar_window_decoder_chk.sv
module bar_window_decoder_chk #(
   parameter int DATA_W = 64,
   parameter int IDX_W  = 4,
   parameter int ADDR_W = 56
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [IDX_W-1:0]  wr_idx,
   input logic [IDX_W-1:0]  rd_idx,
   input logic [DATA_W-1:0] rd_data,
   input logic [3:0]        win_hit,
   input logic [3:0]        win_sel,
   input logic              no_hit,
   input logic [ADDR_W-1:0] sel_offset,
   input logic              bar_err
);

   // R1: first cycle out of reset decodes nothing
   p_reset_nohit_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> no_hit && !bar_err);

   // R2: enable register low bits never read back set
   p_en_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_idx == IDX_W'(0)) |-> (rd_data[DATA_W-5:0] == '0));

   // R5: unmapped indexes read zero
   p_unmapped_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_idx >= IDX_W'(8)) |-> (rd_data == '0));

   // R8: winner is a single hitting window
   p_sel_in_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (win_sel & ~win_hit) == 4'b0000);

   p_sel_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (win_hit != 4'b0000) |-> ($countones(win_sel) == 1));

   p_prio_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
      win_hit[0] |-> (win_sel == 4'b0001));

   p_nohit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      no_hit |-> (win_hit == 4'b0000) && (win_sel == 4'b0000));

   p_hit_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !no_hit |-> (win_hit != 4'b0000));

   // R9: no offset without a winner
   p_off_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      no_hit |-> (sel_offset == '0));

   // R10: error only follows a write to a guarded register
   p_err_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
      bar_err |-> $past(wr_en) && ($past(wr_idx) >= IDX_W'(2)) && ($past(wr_idx) <= IDX_W'(7)));

   // R11: no write, no error
   p_err_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> !bar_err);

endmodule

bind bar_window_decoder bar_window_decoder_chk #(
   .DATA_W (DATA_W),
   .IDX_W  (IDX_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_idx     (wr_idx),
   .rd_idx     (rd_idx),
   .rd_data    (rd_data),
   .win_hit    (win_hit),
   .win_sel    (win_sel),
   .no_hit     (no_hit),
   .sel_offset (sel_offset),
   .bar_err    (bar_err)
);

// File: tb/bar_window_decoder_test.sv
`timescale 1ns/1ps
module bar_window_decoder_test;

   localparam int DATA_W = 64;
   localparam int IDX_W  = 4;
   localparam int ADDR_W = 56;
   localparam longint unsigned AMASK = (64'd1 << ADDR_W) - 1;
   localparam longint unsigned REGSZ = 64'd1024 * 64'd8;
   localparam longint unsigned INTSZ = 64'd256 << 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [IDX_W-1:0]  wr_idx = '0;
   logic [DATA_W-1:0] wr_data = '0;
   logic [IDX_W-1:0]  rd_idx = '0;
   logic [DATA_W-1:0] rd_data;
   logic [ADDR_W-1:0] addr = '0;
   logic [3:0]        win_hit;
   logic [3:0]        win_sel;
   logic              no_hit;
   logic [ADDR_W-1:0] sel_offset;
   logic              bar_err;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   longint unsigned sh [8];

   always #2.5 clk = ~clk;

   bar_window_decoder uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .rd_idx(rd_idx), .rd_data(rd_data), .addr(addr), .win_hit(win_hit),
      .win_sel(win_sel), .no_hit(no_hit), .sel_offset(sel_offset), .bar_err(bar_err)
   );

   task automatic chk(input bit ok, input string req, input longint unsigned act,
                      input longint unsigned exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic longint unsigned keep(input int idx);
      case (idx)
         0:          return 64'hF000_0000_0000_0000;
         1:          return 64'hFF00_0000_0000_0000;
         2, 3, 4, 5: return 64'hFFFF_FFFF_FF00_0000;
         6:          return 64'hFFFF_FFFF_FFC0_0000;
         7:          return 64'hFFFF_FFF0_0000_0000;
         default:    return 64'h0;
      endcase
   endfunction

   function automatic string req_of(input int idx);
      if (idx <= 1) return "R2";
      if (idx <= 5) return "R3";
      if (idx <= 7) return "R4";
      return "R5";
   endfunction

   function automatic longint unsigned wbase(input int w);
      case (w)
         0: return sh[2] >> 8;
         1: return sh[4] >> 8;
         2: return sh[6] >> 8;
         default: return sh[7] >> 8;
      endcase
   endfunction

   function automatic longint unsigned wsize(input int w);
      case (w)
         0: return ((~sh[3]) >> 8) + 1;
         1: return ((~sh[5]) >> 8) + 1;
         2: return REGSZ;
         default: return INTSZ;
      endcase
   endfunction

   function automatic bit wen(input int w);
      return sh[0][63-w];
   endfunction

   task automatic wr(input int idx, input longint unsigned data);
      bit exp_err;
      longint unsigned exp_rd;
      exp_err = 0;
      if (idx >= 2 && idx <= 7) begin
         int w;
         w = (idx <= 3) ? 0 : (idx <= 5) ? 1 : (idx == 6) ? 2 : 3;
         exp_err = wen(w);
      end
      if (idx < 8) sh[idx] = data & keep(idx);
      exp_rd = (idx < 8) ? sh[idx] : 64'h0;
      @(negedge clk);
      wr_en = 1'b1; wr_idx = IDX_W'(idx); wr_data = data;
      @(posedge clk);
      #1;
      wr_en = 1'b0;
      rd_idx = IDX_W'(idx);
      #1;
      chk(bar_err == exp_err, exp_err ? "R10" : "R11", 64'(bar_err), 64'(exp_err));
      chk(rd_data == exp_rd, req_of(idx), rd_data, exp_rd);
   endtask

   task automatic chk_addr(input longint unsigned a);
      logic [3:0] eh, es;
      longint unsigned eo;
      bit taken;
      a = a & AMASK;
      eh = '0; es = '0; eo = 0; taken = 0;
      for (int w = 0; w < 4; w++) begin
         if (wen(w) && a >= wbase(w) && a < wbase(w) + wsize(w)) begin
            eh[w] = 1'b1;
            if (!taken) begin
               taken = 1; es[w] = 1'b1; eo = (a - wbase(w)) & AMASK;
            end
         end
      end
      @(negedge clk);
      addr = ADDR_W'(a);
      #1;
      chk(win_hit == eh, "R6 R7 hit", 64'(win_hit), 64'(eh));
      chk(win_sel == es, "R8 select", 64'(win_sel), 64'(es));
      chk(no_hit == !taken, "R8 no_hit", 64'(no_hit), 64'(!taken));
      chk(64'(sel_offset) == eo, "R9 offset", 64'(sel_offset), eo);
   endtask

   task automatic read_all(input string tag);
      for (int i = 0; i < 16; i++) begin
         longint unsigned e;
         e = (i < 8) ? sh[i] : 64'h0;
         @(negedge clk);
         rd_idx = IDX_W'(i);
         #1;
         chk(rd_data == e, tag, rd_data, e);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog R1 actual=hung expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      for (int i = 0; i < 8; i++) sh[i] = 0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: reset state
      chk(bar_err == 1'b0, "R1 err", 64'(bar_err), 0);
      read_all("R1 reset read");
      chk_addr(64'h0);
      chk_addr(64'h1234_5678_9ABC);

      // R2, R3, R4: implemented bits
      for (int i = 0; i < 8; i++) wr(i, 64'hFFFF_FFFF_FFFF_FFFF);
      wr(0, 64'h0);
      for (int i = 1; i < 8; i++) wr(i, 64'h0);

      // R5: unmapped writes ignored
      wr(1, 64'hAB00_0000_0000_0000);
      wr(9, 64'hFFFF_FFFF_FFFF_FFFF);
      wr(15, 64'h1234_5678_9ABC_DEF0);
      read_all("R5 unmapped write");

      // directed windows
      wr(2, 64'h0000_0100_0000_0000);  // io0 phys 0x1_0000_0000
      wr(3, 64'hFFFF_FFFF_F000_0000);  // io0 1 MiB
      wr(6, 64'h0000_0200_0000_0000);  // regs phys 0x2_0000_0000
      wr(7, 64'h0000_0400_0000_0000);  // intr phys 0x4_0000_0000
      chk_addr(64'h1_0000_0000);        // R6 disabled
      wr(0, 64'hB000_0000_0000_0000);   // io0, regs, intr on
      chk_addr(64'h0_FFFF_FFFF);
      chk_addr(64'h1_0000_0000);
      chk_addr(64'h1_000F_FFFF);
      chk_addr(64'h1_0010_0000);
      // R6 explicit boundary
      @(negedge clk); addr = ADDR_W'(64'h1_000F_FFFF); #1;
      chk(win_sel == 4'b0001 && sel_offset == ADDR_W'(20'hFFFFF), "R6 last byte",
          64'(sel_offset), 64'hFFFFF);
      @(negedge clk); addr = ADDR_W'(64'h1_0010_0000); #1;
      chk(no_hit == 1'b1, "R6 end excluded", 64'(no_hit), 1);
      // R7 fixed sizes
      chk_addr(64'h2_0000_1FFF);
      chk_addr(64'h2_0000_2000);
      chk_addr(64'h4_00FF_FFFF);
      chk_addr(64'h4_0100_0000);
      @(negedge clk); addr = ADDR_W'(64'h2_0000_2000); #1;
      chk(no_hit == 1'b1, "R7 reg window end", 64'(no_hit), 1);
      @(negedge clk); addr = ADDR_W'(64'h4_00FF_FFFF); #1;
      chk(win_sel == 4'b1000 && sel_offset == ADDR_W'(24'hFFFFFF), "R7 int window last",
          64'(sel_offset), 64'hFFFFFF);

      // R10: rewrite live base, R11: disabled window rewrite
      wr(2, 64'h0000_0100_0000_0000);
      wr(3, 64'hFFFF_FFFF_F000_0000);
      wr(4, 64'h0000_0100_0000_0000);   // io1 disabled
      wr(5, 64'hFFFF_FFFF_0000_0000);   // io1 16 MiB
      wr(6, 64'h0000_0100_8000_0000);   // regs live -> err, inside io1
      wr(1, 64'h5500_0000_0000_0000);   // R11 mode
      wr(0, 64'hF000_0000_0000_0000);   // R11 enable

      // R8 priority in overlap
      chk_addr(64'h1_0000_0010);
      @(negedge clk); addr = ADDR_W'(64'h1_0000_0010); #1;
      chk(win_sel == 4'b0001 && win_hit == 4'b0011, "R8 io0 over io1",
          64'(win_sel), 64'h1);
      chk_addr(64'h1_0020_0000);
      chk_addr(64'h1_0080_0010);
      @(negedge clk); addr = ADDR_W'(64'h1_0080_0010); #1;
      chk(win_sel == 4'b0010 && win_hit == 4'b0110, "R8 io1 over regs",
          64'(win_sel), 64'h2);
      wr(0, 64'h3000_0000_0000_0000);
      chk_addr(64'h1_0080_0010);
      @(negedge clk); addr = ADDR_W'(64'h1_0080_0010); #1;
      chk(win_sel == 4'b0100 && sel_offset == ADDR_W'(8'h10), "R9 regs offset",
          64'(sel_offset), 64'h10);

      // random mix
      for (int r = 0; r < 150; r++) begin
         for (int k = 0; k < 3; k++) begin
            int idx;
            longint unsigned d;
            idx = int'($urandom % 16);
            d = {$urandom, $urandom};
            if (idx >= 2 && idx <= 7 && (idx % 2 == 0 || idx == 7))
               d = d & 64'h0000_00FF_FFFF_FFFF;
            else if (idx == 3 || idx == 5) begin
               if ($urandom % 4 != 0)
                  d = ~((64'd1 << (24 + ($urandom % 16))) - 1) | (d & 64'hFFFFFF);
            end
            wr(idx, d);
         end
         for (int k = 0; k < 16; k++) begin
            int w;
            longint unsigned a;
            w = int'($urandom % 5);
            if (w < 4)
               a = wbase(w) + 64'($urandom % 32'h0200_0000) - 64'd64;
            else
               a = {$urandom, $urandom};
            chk_addr(a);
         end
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule